// File: doc/BRIEF.md
# Multi-Block Flash Erase Sequencer

This block controls the erase of a flash array built from eight main blocks and one shadow row. Software chooses blocks with a select bitmask. An independent lock bitmask protects blocks, and a locked block is never erased even when it is selected. The erase set that takes effect is select AND NOT lock. It is captured when a start is accepted. The sequencer then erases the blocks in that set one at a time, from the lowest index to the highest. For each block it raises a one-cycle erase strobe, with the block index on `cur_blk`, and then waits for the array to return its completion pulse before moving on.

A shadow-row mode ignores the select and lock masks and erases only the shadow row, which has index 8. The sequence is armed by the erase-mode input rising from 0 to 1, and a start strobe issued later launches it. An abort stops the walk. The block whose erase was in progress is then flagged as indeterminate in a sticky per-block status vector. A later completed erase of that block clears its flag.

Top module: `flash_erase_seq`

## Requirements
- R1: Each block erase is a single-cycle `erase_stb` with `cur_blk` holding the block index. No further strobe is issued until `blk_done` has been returned for that block. When the sequence completes, every block that was erased reads all ones in the array.
- R2: The erase set is `sel_mask & ~lock_mask`, captured when start is accepted. A block whose lock bit is 1 never receives a strobe, and a block whose select bit is 0 never receives a strobe.
- R3: The blocks of the erase set are strobed in strictly ascending index order, each exactly once. Blocks outside the set keep their contents.
- R4: When `shadow_mode` is 1 at an accepted start, the select and lock masks are ignored. Exactly one strobe is issued, with `cur_blk` = 8, which is the shadow row.
- R5: A start is accepted only while `erase_mode` is 1, and only if `erase_mode` rose from 0 to 1 at least one cycle earlier and no start has been accepted since that rise. Any other start has no effect: no strobe is issued and `seq_done` stays low.
- R6: If the erase set is empty, `seq_done` is 1 in the cycle after the accepted start, and no strobe is issued.
- R7: `seq_done` is a single-cycle pulse. It goes high in the second cycle after the `blk_done` pulse of the last block in the set.
- R8: An abort while waiting for a block's completion returns the sequencer to idle. No `seq_done` pulse follows, and no further strobes are issued for the remaining blocks.
- R9: `indet` has one bit per block, with bit 8 for the shadow row. An abort sets the bit of the block in progress. The bit stays set through other erases and is cleared only when that same block later completes an erase.
- R10: After reset, `erase_stb`, `seq_done`, `cur_blk` and `indet` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| erase_mode | input | 1 | Erase mode; its rising edge arms a sequence |
| sel_mask | input | 8 | Block select mask, bit i = block i |
| lock_mask | input | 8 | Block lock mask, 1 = protected |
| shadow_mode | input | 1 | Erase only the shadow row, ignoring the masks |
| start | input | 1 | Start strobe |
| abort | input | 1 | Abort strobe |
| blk_done | input | 1 | Single-cycle completion pulse from the array |
| cur_blk | output | 4 | Index of the block being erased (8 = shadow) |
| erase_stb | output | 1 | Single-cycle erase request for `cur_blk` |
| seq_done | output | 1 | Single-cycle sequence-complete pulse |
| indet | output | 9 | Sticky per-block indeterminate flags |

## Verification
Assertions check the following on every cycle:
- every strobe falls inside the captured erase set;
- strobes within one sequence climb strictly in index;
- strobes and the done pulse last one cycle;
- an abort is never followed by done or a strobe;
- an indeterminate flag rises only on an abort.

Some behaviours depend on data or history, and only the bench scenarios can show them:
- the array contents after erase, including untouched locked blocks;
- the exact order and count of strobes against a computed list;
- the ignored start without a fresh mode edge;
- the stickiness of a flag across an unrelated erase, and its clearing by a re-erase.

// File: rtl/fes_pkg.sv
package fes_pkg;
    localparam int unsigned FES_BLOCKS = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } fes_state_e;

    function automatic logic rose(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction
endpackage

// File: rtl/fes_pick.sv
module fes_pick #(
    parameter int unsigned W  = 9,
    parameter int unsigned IW = 4
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign any = |vec;
endmodule

// File: rtl/fes_indet.sv
module fes_indet #(
    parameter int unsigned W  = 9,
    parameter int unsigned IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  flags
);
    for (genvar g = 0; g < W; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                                  flags[g] <= 1'b0;
            else if (set_en && idx == IW'(g))         flags[g] <= 1'b1;
            else if (clr_en && idx == IW'(g))         flags[g] <= 1'b0;
        end
    end

    // a flag may only appear in the cycle after an abort hit
    assert_set_only_abort_R9: assert property (@(posedge clk) disable iff (rst)
        !set_en |=> ((flags & ~$past(flags)) == '0));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int unsigned NUM_BLK = FES_BLOCKS,
    parameter int unsigned IDX_W   = $clog2(NUM_BLK + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               erase_mode,
    input  logic [NUM_BLK-1:0] sel_mask,
    input  logic [NUM_BLK-1:0] lock_mask,
    input  logic               shadow_mode,
    input  logic               start,
    input  logic               abort,
    input  logic               blk_done,
    output logic [IDX_W-1:0]   cur_blk,
    output logic               erase_stb,
    output logic               seq_done,
    output logic [NUM_BLK:0]   indet
);
    localparam int unsigned     SET_W      = NUM_BLK + 1;
    localparam logic [IDX_W-1:0] SHADOW_IDX = IDX_W'(NUM_BLK);

    typedef struct packed {
        logic [SET_W-1:0] pend;
        logic [SET_W-1:0] granted;
    } job_t;

    fes_state_e       state;
    job_t             job_q;
    logic             mode_d;
    logic             armed;
    logic             accept;
    logic [SET_W-1:0] new_set;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_any;
    logic             ab_hit;
    logic             cmp_hit;

    assign accept  = (state == ST_IDLE) && start && erase_mode && armed;
    assign new_set = shadow_mode ? {1'b1, {NUM_BLK{1'b0}}}
                                 : {1'b0, sel_mask & ~lock_mask};
    assign ab_hit  = (state == ST_WAIT) && abort;
    assign cmp_hit = (state == ST_WAIT) && !abort && blk_done;

    fes_pick #(.W(SET_W), .IW(IDX_W)) pick_i (
        .vec (job_q.pend),
        .idx (pick_idx),
        .any (pick_any)
    );

    fes_indet #(.W(SET_W), .IW(IDX_W)) indet_i (
        .clk    (clk),
        .rst    (rst),
        .set_en (ab_hit),
        .clr_en (cmp_hit),
        .idx    (cur_blk),
        .flags  (indet)
    );

    // arming: the mode edge must precede start
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_d <= 1'b0;
            armed  <= 1'b0;
        end else begin
            mode_d <= erase_mode;
            if (!erase_mode)                 armed <= 1'b0;
            else if (rose(erase_mode, mode_d)) armed <= 1'b1;
            else if (accept)                 armed <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            job_q     <= '0;
            cur_blk   <= '0;
            erase_stb <= 1'b0;
            seq_done  <= 1'b0;
        end else begin
            erase_stb <= 1'b0;
            seq_done  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        job_q.granted <= new_set;
                        job_q.pend    <= new_set;
                        if (new_set == '0) seq_done <= 1'b1;
                        else               state    <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (abort) begin
                        job_q.pend <= '0;
                        state      <= ST_IDLE;
                    end else if (!pick_any) begin
                        seq_done <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        cur_blk   <= pick_idx;
                        erase_stb <= 1'b1;
                        state     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (abort) begin
                        job_q.pend <= '0;
                        state      <= ST_IDLE;
                    end else if (blk_done) begin
                        job_q.pend <= job_q.pend & ~(SET_W'(1) << cur_blk);
                        state      <= ST_ISSUE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // checker state: last strobed index within the current sequence
    logic [IDX_W-1:0] last_idx;
    logic             seen_stb;
    always_ff @(posedge clk) begin
        if (rst || accept) begin
            last_idx <= '0;
            seen_stb <= 1'b0;
        end else if (erase_stb) begin
            last_idx <= cur_blk;
            seen_stb <= 1'b1;
        end
    end

    assert_stb_in_set_R2: assert property (@(posedge clk) disable iff (rst)
        erase_stb |-> |(job_q.granted & (SET_W'(1) << cur_blk)));

    assert_ascending_R3: assert property (@(posedge clk) disable iff (rst)
        (erase_stb && seen_stb) |-> (cur_blk > last_idx));

    assert_shadow_idx_R4: assert property (@(posedge clk) disable iff (rst)
        (erase_stb && job_q.granted[NUM_BLK]) |-> (cur_blk == SHADOW_IDX));

    assert_stb_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        erase_stb |=> !erase_stb);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !seq_done);

    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        ab_hit |=> (!seq_done && !erase_stb));
endmodule

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;
    localparam int NB        = 8;
    localparam int ERASE_CYC = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          erase_mode = 1'b0;
    logic [NB-1:0] sel_mask = '0;
    logic [NB-1:0] lock_mask = '0;
    logic          shadow_mode = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic          blk_done;
    logic [3:0]    cur_blk;
    logic          erase_stb;
    logic          seq_done;
    logic [NB:0]   indet;

    always #2 clk = ~clk;

    flash_erase_seq dut_i (
        .clk(clk), .rst(rst), .erase_mode(erase_mode), .sel_mask(sel_mask),
        .lock_mask(lock_mask), .shadow_mode(shadow_mode), .start(start),
        .abort(abort), .blk_done(blk_done), .cur_blk(cur_blk),
        .erase_stb(erase_stb), .seq_done(seq_done), .indet(indet)
    );

    // behavioural array model and activity log
    logic [15:0] mem [0:NB];
    int          cnt;
    logic [3:0]  tgt;
    logic        fill_req = 1'b0;
    logic        clr_log = 1'b0;
    int          log_q [0:15];
    int          nlog;
    int          ndone;

    always @(posedge clk) begin
        blk_done <= 1'b0;
        if (rst) begin
            cnt <= 0;
            tgt <= '0;
        end else if (erase_stb) begin
            cnt <= ERASE_CYC;
            tgt <= cur_blk;
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                blk_done <= 1'b1;
                mem[tgt] <= 16'hFFFF;
            end
        end
        if (fill_req) begin
            for (int i = 0; i <= NB; i++) mem[i] <= 16'h1230 + 16'(i);
        end
    end

    always @(posedge clk) begin
        if (rst || clr_log) begin
            nlog  <= 0;
            ndone <= 0;
        end else begin
            if (erase_stb && nlog < 16) begin
                log_q[nlog] <= int'(cur_blk);
                nlog        <= nlog + 1;
            end
            if (seq_done) ndone <= ndone + 1;
        end
    end

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NB:0] eff_set(input logic [NB-1:0] s, input logic [NB-1:0] l,
                                            input logic sh);
        if (sh) return {1'b1, {NB{1'b0}}};
        return {1'b0, s & ~l};
    endfunction

    function automatic int pop(input logic [NB:0] v);
        int c = 0;
        for (int i = 0; i <= NB; i++) if (v[i]) c++;
        return c;
    endfunction

    // arm with a fresh mode edge, pulse start
    task automatic launch(input logic [NB-1:0] s, input logic [NB-1:0] l, input logic sh);
        @(negedge clk);
        erase_mode = 1'b0;
        fill_req = 1'b1;
        clr_log = 1'b1;
        @(negedge clk);
        fill_req = 1'b0;
        clr_log = 1'b0;
        sel_mask = s;
        lock_mask = l;
        shadow_mode = sh;
        erase_mode = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (ndone > 0) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic full_run(input logic [NB-1:0] s, input logic [NB-1:0] l, input logic sh);
        logic [NB:0] e;
        bit ok;
        int k;
        e = eff_set(s, l, sh);
        launch(s, l, sh);
        wait_done(ok);
        chk(ok, "R7 done reached", int'(ok), 1);
        repeat (3) @(negedge clk);
        chk(ndone == 1, "R7 single done pulse", ndone, 1);
        chk(nlog == pop(e), "R2 strobe count", nlog, pop(e));
        k = 0;
        for (int i = 0; i <= NB; i++) begin
            if (e[i]) begin
                if (k < nlog)
                    chk(log_q[k] == i, sh ? "R4 shadow index" : "R3 ascending order", log_q[k], i);
                k++;
            end
        end
        for (int i = 0; i <= NB; i++) begin
            if (e[i]) chk(mem[i] == 16'hFFFF, "R1 erased all ones", int'(mem[i]), 16'hFFFF);
            else      chk(mem[i] == 16'h1230 + 16'(i), "R3 untouched block", int'(mem[i]),
                          32'h1230 + i);
        end
    endtask

    task automatic abort_run(input logic [NB-1:0] s, input logic sh);
        bit got;
        launch(s, '0, sh);
        got = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (nlog > 0) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(got, "R8 first strobe before abort", int'(got), 1);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        repeat (30) @(negedge clk);
        chk(ndone == 0, "R8 no done after abort", ndone, 0);
        chk(nlog == 1, "R8 no strobes after abort", nlog, 1);
    endtask

    bit wd_fired = 1'b0;
    initial begin
        repeat (150000) @(posedge clk);
        wd_fired = 1'b1;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [NB-1:0] rs, rl;
        logic          rsh;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(erase_stb == 1'b0, "R10 strobe low", int'(erase_stb), 0);
        chk(seq_done == 1'b0, "R10 done low", int'(seq_done), 0);
        chk(cur_blk == 4'd0, "R10 index zero", int'(cur_blk), 0);
        chk(indet == '0, "R10 indet clear", int'(indet), 0);

        // R6 empty set: done in cycle after start
        launch(8'h0F, 8'hFF, 1'b0);
        chk(seq_done == 1'b1, "R6 done next cycle", int'(seq_done), 1);
        repeat (3) @(negedge clk);
        chk(nlog == 0, "R6 no strobe", nlog, 0);

        // directed mask cases
        full_run(8'hFF, 8'h00, 1'b0);
        full_run(8'hA5, 8'h21, 1'b0);
        full_run(8'h81, 8'h00, 1'b0);
        full_run(8'hFF, 8'h00, 1'b1);   // R4 select ignored
        full_run(8'h00, 8'hFF, 1'b1);   // R4 locks ignored

        // R5 start without a fresh mode edge
        @(negedge clk);
        clr_log = 1'b1;
        @(negedge clk);
        clr_log = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk(nlog == 0, "R5 rearm needed no strobe", nlog, 0);
        chk(ndone == 0, "R5 rearm needed no done", ndone, 0);

        // R8 / R9 abort, stickiness, recovery
        abort_run(8'h24, 1'b0);
        chk(indet == 9'h004, "R9 flag set by abort", int'(indet), 9'h004);
        full_run(8'h40, 8'h00, 1'b0);
        chk(indet == 9'h004, "R9 flag sticky", int'(indet), 9'h004);
        full_run(8'h04, 8'h00, 1'b0);
        chk(indet == 9'h000, "R9 flag cleared by re-erase", int'(indet), 0);
        abort_run(8'h00, 1'b1);
        chk(indet == 9'h100, "R9 shadow flag set", int'(indet), 9'h100);
        full_run(8'h00, 8'h00, 1'b1);
        chk(indet == 9'h000, "R9 shadow flag cleared", int'(indet), 0);

        // constrained random
        for (int it = 0; it < 24; it++) begin
            rs  = NB'($urandom);
            rl  = NB'($urandom) & NB'($urandom);
            rsh = ($urandom % 6) == 0;
            full_run(rs, rl, rsh);
        end

        if (!wd_fired) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule